// File: doc/BRIEF.md
# Three-State Memory Bus Cycle Sequencer

This block turns memory requests from a small 8-bit processor core into external bus cycles. It runs on the oscillator clock, and one clock period is one half-state. A state is two clocks. A basic machine cycle has three states, T1, T2 and T3, so it takes six clocks when no wait states are added. The core offers a request with a cycle kind, an address and write data. The block accepts the request only when it is idle or in the last half-state of the cycle in progress.

For each accepted request the block drives the address bus and sequences the active-low memory enable, read, write and instruction-fetch strobes. It also sequences the data-bus output enable. The two read-type cycles sample the data bus at different edges: an opcode fetch samples one half-state earlier than a data read. A write asserts its write strobe half a state after memory enable and keeps the data driven to the end of T3. A wait input, checked early in T2, inserts whole two-clock wait states between T2 and T3 and holds every strobe. The captured byte is returned with a one-clock done pulse, and the same pulse also marks the end of a write.

Top module: `mem_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. In idle, `mem_en_n`, `mem_rd_n`, `mem_wr_n` and `fetch_n` are high, `dbus_oe` and `rsp_done` are low, and `req_ready` is high. This also holds when reset arrives in the middle of a cycle.
- R2: `req_ready` is high only in idle and in the second half of T3. A request is taken at an edge where `req_valid` and `req_ready` are both high. The next clock is the first half of T1. With no waits, a cycle lasts six clocks: T1a, T1b, T2a, T2b, T3a, T3b.
- R3: `mem_addr` shows the accepted address from T1a through T3b and stays stable for the whole cycle.
- R4: For `req_kind` 2'b00 (opcode fetch) and 2'b01 (data read), `mem_en_n` and `mem_rd_n` are low from T1b through T3a and high otherwise. `mem_wr_n` stays high.
- R5: `fetch_n` is low from T1a through T3a only when `req_kind` is 2'b00. It stays high for every other kind.
- R6: An opcode fetch samples `dbus_in` at the edge that ends T2, or at the edge that ends the last wait state if there are any. That value appears on `rsp_rdata` from T3a.
- R7: A data read samples `dbus_in` at the edge that ends T3a, one half-state later than a fetch. `req_kind` 2'b11 behaves exactly like a data read.
- R8: For `req_kind` 2'b10 (write), `mem_en_n` is low from T1b through T3a. `mem_wr_n` is low from T2a through T3a. `mem_rd_n` and `fetch_n` stay high.
- R9: During a write, `dbus_oe` is high from T1b through T3b and `dbus_out` carries the accepted write data. `dbus_oe` is low at all other times.
- R10: `bus_wait` is sampled at the edge ending T2a and at the edge ending each wait state's first half. When it is high, one two-clock wait state follows T2 (or follows the current wait state). All strobes, the address and the output enable are held through it.
- R11: `rsp_done` is a one-clock pulse in T3b of every cycle. `rsp_rdata` keeps its value until the next read-type capture, so a write leaves it unchanged.
- R12: A request present during T3b starts its T1a on the very next clock, with no idle clock between the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per half-state |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Request can be taken at this edge |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse in T3b |
| rsp_rdata | output | DATA_W | Last captured read or fetch byte |
| mem_addr | output | ADDR_W | External address bus |
| mem_en_n | output | 1 | Memory enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| fetch_n | output | 1 | Instruction-fetch indicator, active low |
| dbus_out | output | DATA_W | Data bus drive value |
| dbus_oe | output | 1 | Data bus output enable |
| dbus_in | input | DATA_W | Data bus input value |
| bus_wait | input | 1 | Wait request from memory |

## Verification
The bench builds the block with a 16-bit address and an 8-bit data bus. These are small enough to give each cycle a distinct address, and the data width lets the bench put a different byte on the data bus in every half-state. Because the byte changes each half-state, the captured byte shows exactly which edge sampled the bus. This separates the fetch sampling point from the read sampling point, and it shows how both move when zero to three wait states are added. Back-to-back chains and a reset in mid-cycle reach the acceptance window in T3b and the abort path.

// File: rtl/mem_cycle_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the memory bus cycle sequencer.
// Assumes one clock period equals one half-state of the bus timing.
package mem_cycle_pkg;

    // Half-state position inside a machine cycle; TW* are wait-state halves.
    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,
        PH_T1A  = 4'd1,
        PH_T1B  = 4'd2,
        PH_T2A  = 4'd3,
        PH_T2B  = 4'd4,
        PH_TWA  = 4'd5,
        PH_TWB  = 4'd6,
        PH_T3A  = 4'd7,
        PH_T3B  = 4'd8
    } bus_phase_t;

    // Cycle kind as presented by the core; CK_ALTRD behaves as a data read.
    typedef enum logic [1:0] {
        CK_FETCH = 2'b00,
        CK_READ  = 2'b01,
        CK_WRITE = 2'b10,
        CK_ALTRD = 2'b11
    } cyc_kind_t;

    function automatic logic kind_is_write(input cyc_kind_t k);
        return (k == CK_WRITE);
    endfunction

    function automatic logic kind_is_fetch(input cyc_kind_t k);
        return (k == CK_FETCH);
    endfunction

endpackage

// File: rtl/mem_cycle_phase.sv
`timescale 1ns/1ps
// Module: mem_cycle_phase
// Walks the half-state sequence T1a..T3b, with optional wait states, for
// one machine cycle. Accepts a request in idle or in T3b. Samples the wait
// input at the edge ending T2a and at the edge ending each TWa.
// Assumes bus_wait is synchronous to clk.
module mem_cycle_phase
    import mem_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_wait,
    output logic       req_ready,
    output logic       accept,
    output bus_phase_t phase_q,
    output logic       wait_q
);

    bus_phase_t phase_d;

    // Acceptance window: idle or the final half-state of a cycle.
    always_comb begin
        req_ready = (phase_q == PH_IDLE) || (phase_q == PH_T3B);
        accept    = req_ready && req_valid;
    end

    // Next half-state selection.
    always_comb begin
        case (phase_q)
            PH_IDLE: phase_d = accept ? PH_T1A : PH_IDLE;
            PH_T1A:  phase_d = PH_T1B;
            PH_T1B:  phase_d = PH_T2A;
            PH_T2A:  phase_d = PH_T2B;
            PH_T2B:  phase_d = wait_q ? PH_TWA : PH_T3A;
            PH_TWA:  phase_d = PH_TWB;
            PH_TWB:  phase_d = wait_q ? PH_TWA : PH_T3A;
            PH_T3A:  phase_d = PH_T3B;
            PH_T3B:  phase_d = accept ? PH_T1A : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Half-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Wait decision, latched in the first half of T2 or of a wait state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= 1'b0;
        else if (phase_q == PH_T2A || phase_q == PH_TWA)
            wait_q <= bus_wait;
        else if (phase_q == PH_T3A)
            wait_q <= 1'b0;
    end

    // R2
    accept_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (phase_q == PH_T1A));

    // R10
    wait_inserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_T2A && bus_wait) |=> ##1 (phase_q == PH_TWA));

    // R10
    no_wait_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_T2A && !bus_wait) |=> ##1 (phase_q == PH_T3A));

endmodule

// File: rtl/mem_cycle_strobes.sv
`timescale 1ns/1ps
// Module: mem_cycle_strobes
// Decodes the current half-state and cycle kind into the active-low bus
// strobes and the data-bus output enable. The strobes are pure decode of
// registered state, so they change only right after a clock edge.
module mem_cycle_strobes
    import mem_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_phase_t phase_q,
    input  cyc_kind_t  kind_q,
    output logic       mem_en_n,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       fetch_n,
    output logic       dbus_oe
);

    logic body_win;
    logic wr_win;
    logic fetch_win;
    logic drive_win;
    logic is_wr;
    logic is_fetch;

    // Half-state windows shared by every cycle kind.
    always_comb begin
        body_win  = phase_q inside {PH_T1B, PH_T2A, PH_T2B, PH_TWA, PH_TWB, PH_T3A};
        wr_win    = phase_q inside {PH_T2A, PH_T2B, PH_TWA, PH_TWB, PH_T3A};
        fetch_win = phase_q inside {PH_T1A, PH_T1B, PH_T2A, PH_T2B, PH_TWA, PH_TWB, PH_T3A};
        drive_win = phase_q inside {PH_T1B, PH_T2A, PH_T2B, PH_TWA, PH_TWB, PH_T3A, PH_T3B};
    end

    // Kind qualifiers.
    always_comb begin
        is_wr    = kind_is_write(kind_q);
        is_fetch = kind_is_fetch(kind_q);
    end

    // Strobe outputs, active low except the output enable.
    always_comb begin
        mem_en_n = !body_win;
        mem_rd_n = !(body_win && !is_wr);
        mem_wr_n = !(wr_win && is_wr);
        fetch_n  = !(fetch_win && is_fetch);
        dbus_oe  = drive_win && is_wr;
    end

    // R8
    wr_inside_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> !mem_en_n);

    // R8
    wr_lags_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(!mem_en_n));

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R9
    wr_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> dbus_oe);

endmodule

// File: rtl/mem_cycle_data.sv
`timescale 1ns/1ps
// Module: mem_cycle_data
// Holds the accepted address, kind and write data for the whole cycle, and
// captures the data bus at the kind-specific edge. A fetch samples at the
// end of T2 or of the last wait state. A read samples at the end of T3a.
// Assumes dbus_in is settled at the sampling edge.
module mem_cycle_data
    import mem_cycle_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  bus_phase_t        phase_q,
    input  logic              wait_q,
    input  logic [DATA_W-1:0] dbus_in,
    output cyc_kind_t         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic fetch_smp;
    logic read_smp;

    // Request latch, loaded on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CK_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= cyc_kind_t'(req_kind);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sampling points for the two read-type kinds.
    always_comb begin
        fetch_smp = (kind_q == CK_FETCH) && !wait_q &&
                    (phase_q == PH_T2B || phase_q == PH_TWB);
        read_smp  = (kind_q == CK_READ || kind_q == CK_ALTRD) && (phase_q == PH_T3A);
    end

    // Read data capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata_q <= '0;
        else if (fetch_smp || read_smp) rdata_q <= dbus_in;
    end

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && phase_q != PH_T1A) |-> $stable(addr_q));

    // R11
    rdata_early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q inside {PH_T1A, PH_T1B, PH_T2A}) |=> $stable(rdata_q));

endmodule

// File: rtl/mem_cycle_seq.sv
`timescale 1ns/1ps
// Module: mem_cycle_seq (top)
// Three-state external memory bus cycle sequencer. One clock is one
// half-state. Ties together the phase walker, the strobe decode and the
// address/data path. Assumes all inputs are synchronous to clk.
module mem_cycle_seq
    import mem_cycle_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              fetch_n,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    input  logic [DATA_W-1:0] dbus_in,
    input  logic              bus_wait
);

    bus_phase_t        phase_q;
    cyc_kind_t         kind_q;
    logic              wait_q;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    mem_cycle_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_wait  (bus_wait),
        .req_ready (req_ready),
        .accept    (accept),
        .phase_q   (phase_q),
        .wait_q    (wait_q)
    );

    mem_cycle_data #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase_q   (phase_q),
        .wait_q    (wait_q),
        .dbus_in   (dbus_in),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_q)
    );

    mem_cycle_strobes u_strobes (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_q  (phase_q),
        .kind_q   (kind_q),
        .mem_en_n (mem_en_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .fetch_n  (fetch_n),
        .dbus_oe  (dbus_oe)
    );

    // Output mapping: bus drive gated by the enable, done in T3b.
    always_comb begin
        mem_addr  = addr_q;
        dbus_out  = dbus_oe ? wdata_q : '0;
        rsp_rdata = rdata_q;
        rsp_done  = (phase_q == PH_T3B);
    end

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R10
    wait_holds_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TWB) |-> $stable({mem_en_n, mem_rd_n, mem_wr_n, fetch_n, dbus_oe}));

endmodule

// File: tb/mem_cycle_seq_bench.sv
`timescale 1ns/1ps
module mem_cycle_seq_bench;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_en_n, mem_rd_n, mem_wr_n, fetch_n, dbus_oe;
    logic [DW-1:0] dbus_out;
    logic [DW-1:0] dbus_in = '0;
    logic          bus_wait = 1'b0;

    int            n_chk = 0;
    int            n_err = 0;
    logic [DW-1:0] last_rd = '0;

    always #2.5 clk = ~clk;

    mem_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_mem_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_en_n(mem_en_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .fetch_n(fetch_n), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
        .dbus_in(dbus_in), .bus_wait(bus_wait)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Idle outputs (R1 state), checked after a posedge.
    task automatic chk_idle(input string tag);
        chk({tag, " R1 en_n"}, 32'(mem_en_n), 32'd1);
        chk({tag, " R1 rd_n"}, 32'(mem_rd_n), 32'd1);
        chk({tag, " R1 wr_n"}, 32'(mem_wr_n), 32'd1);
        chk({tag, " R1 fetch_n"}, 32'(fetch_n), 32'd1);
        chk({tag, " R1 oe"}, 32'(dbus_oe), 32'd0);
        chk({tag, " R1 done"}, 32'(rsp_done), 32'd0);
        chk({tag, " R1 ready"}, 32'(req_ready), 32'd1);
    endtask

    // Runs one machine cycle starting at a negedge; returns at the negedge in T3b.
    task automatic run_cycle(input logic [1:0] kind, input logic [AW-1:0] addr,
                             input logic [DW-1:0] wd, input int nw,
                             input logic [DW-1:0] base, input bit hold);
        int len = 6 + 2 * nw;
        int t3a = len - 2;
        bit wr = (kind == 2'b10);
        bit fe = (kind == 2'b00);
        logic [DW-1:0] cap = fe ? DW'(base + 3 + 2 * nw) : DW'(base + 4 + 2 * nw);
        chk("R2 ready before start", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        @(posedge clk); #1;
        for (int i = 0; i < len; i++) begin
            string p = $sformatf("k%0d w%0d ph%0d", kind, nw, i);
            chk({p, " R3 addr"}, 32'(mem_addr), 32'(addr));
            chk({p, " R4/R8 en_n"}, 32'(mem_en_n), 32'(!(i >= 1 && i <= t3a)));
            chk({p, " R4 rd_n"}, 32'(mem_rd_n), 32'(!(!wr && i >= 1 && i <= t3a)));
            chk({p, " R8 wr_n"}, 32'(mem_wr_n), 32'(!(wr && i >= 2 && i <= t3a)));
            chk({p, " R5 fetch_n"}, 32'(fetch_n), 32'(!(fe && i <= t3a)));
            chk({p, " R9 oe"}, 32'(dbus_oe), 32'(wr && i >= 1));
            if (wr && i >= 1) chk({p, " R9 dbus_out"}, 32'(dbus_out), 32'(wd));
            chk({p, " R11 done"}, 32'(rsp_done), 32'(i == len - 1));
            chk({p, " R2 ready"}, 32'(req_ready), 32'(i == len - 1));
            if (i == t3a)
                chk({p, " R6 fetch captured by T3a"}, 32'(rsp_rdata),
                    32'(fe ? cap : last_rd));
            if (i == len - 1) begin
                if (!wr) last_rd = cap;
                chk({p, " R6/R7/R11 rdata"}, 32'(rsp_rdata), 32'(last_rd));
            end
            @(negedge clk);
            if (!hold) req_valid = 1'b0;
            dbus_in  = DW'(base + i);
            bus_wait = (i >= 2) && (i < 2 + 2 * nw) && (i % 2 == 0);
            if (i == len - 1) break;
            @(posedge clk); #1;
        end
        bus_wait = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            chk_idle("idle");
            @(negedge clk);
        end
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk_idle("in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 chk_idle("after reset");
        chk("R11 rdata reset", 32'(rsp_rdata), 32'd0);
        last_rd = '0;
        @(negedge clk);
    endtask

    task automatic test_fetch_read_nowait;
        run_cycle(2'b00, 16'h1234, 8'h00, 0, 8'h40, 1'b0); // R6
        idle_cycles(2);
        run_cycle(2'b01, 16'h2345, 8'h00, 0, 8'h80, 1'b0); // R7
        idle_cycles(1);
    endtask

    task automatic test_write_nowait;
        run_cycle(2'b10, 16'hBEEF, 8'hA5, 0, 8'h10, 1'b0); // R8 R9 R11
        idle_cycles(1);
    endtask

    task automatic test_waits;
        run_cycle(2'b00, 16'h0F0F, 8'h00, 2, 8'hC0, 1'b0); // R10 R6
        idle_cycles(1);
        run_cycle(2'b01, 16'h7777, 8'h00, 1, 8'h20, 1'b0); // R10 R7
        idle_cycles(1);
        run_cycle(2'b10, 16'h5A5A, 8'h3C, 3, 8'h60, 1'b0); // R10 R9
        idle_cycles(1);
    endtask

    task automatic test_altread;
        run_cycle(2'b11, 16'hFFFF, 8'h00, 0, 8'hE0, 1'b0); // R7 kind 11
        idle_cycles(1);
    endtask

    task automatic test_back_to_back;
        run_cycle(2'b10, 16'h0101, 8'h99, 0, 8'h00, 1'b1); // R12
        run_cycle(2'b00, 16'h0202, 8'h00, 1, 8'h50, 1'b1); // R12
        run_cycle(2'b01, 16'h0303, 8'h00, 0, 8'h90, 1'b0); // R12
        idle_cycles(2);
    endtask

    task automatic test_reset_midcycle;
        req_valid = 1'b1; req_kind = 2'b10; req_addr = 16'h4444; req_wdata = 8'h77;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R8 wr active before abort", 32'(mem_wr_n), 32'd0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 chk_idle("R1 mid-cycle reset");
        @(negedge clk); rst_n = 1'b1;
        last_rd = '0;
        idle_cycles(1);
    endtask

    initial begin
        test_reset();
        test_fetch_read_nowait();
        test_write_nowait();
        test_waits();
        test_altread();
        test_back_to_back();
        test_reset_midcycle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule